// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 64-bit unsigned operands and a single incoming carry. It produces a 64-bit sum and an outgoing carry, and it does so entirely in combinational logic. The operand width is divided into eight slices of eight bits each.

Inside each slice, every bit position forms three terms from its two operand bits: a generate term (AND), a propagate term (inclusive OR) and a half-sum (XOR). The slice reduces its bit terms to one slice-generate and one slice-propagate signal and passes them upward. A separate second-level unit takes the eight slice signals and the incoming carry, and computes the carry into every slice in parallel using fully expanded lookahead terms. The sum bits are then formed locally inside each slice.

The block has no clock and no reset. A surrounding datapath registers the inputs and outputs wherever its timing needs them.

Top module: `cla_adder64`

## Requirements
- R1: The low 64 bits of sum equal the low 64 bits of op_a + op_b + carry_in, for all operand values.
- R2: carry_out is 1 exactly when op_a + op_b + carry_in is greater than or equal to 2^64.
- R3: For every slice k, the eight sum bits at positions 8k to 8k+7 equal the 8-bit sum of the operand bytes at those positions plus the carry entering that slice. The carry into slice 0 is carry_in. The carry into slice k+1 is the carry out of slice k.
- R4: A slice whose operand bytes are bitwise complements passes its incoming carry on unchanged. A slice whose byte addition overflows with no incoming carry emits a carry whatever its incoming carry is. Internally, the slice-generate term equals the carry of the byte addition with incoming carry 0, and (slice-generate OR slice-propagate) equals that carry with incoming carry 1.
- R5: With both operands all ones and carry_in = 1, sum is all ones and carry_out is 1.
- R6: With both operands zero, sum equals carry_in in bit 0 and zeros elsewhere, and carry_out is 0.
- R7: With op_a = 0x5555...5 and op_b = 0xAAAA...A, a carry_in of 1 travels through all 64 positions: sum is 0 and carry_out is 1. With carry_in = 0, sum is all ones and carry_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | First addend |
| op_b | input | 64 | Second addend |
| carry_in | input | 1 | Incoming carry added at bit 0 |
| sum | output | 64 | Low 64 bits of the total |
| carry_out | output | 1 | Carry out of bit 63 |

## Verification
Whenever any input changes, the assertions check the full 65-bit result against an arithmetic reference. They also check each slice's generate and propagate terms against byte additions, and check each carry from the second-level unit against the actual carry out of the slice below it. Only the bench scenarios show the named corner patterns at the ports: the full-length propagate chain under alternating bits, all ones with a carry, zero operands, and complementary slices that pass a carry through unchanged.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned SLICE_W  = 8;
  localparam int unsigned N_SLICES = 8;
  localparam int unsigned ADD_W    = SLICE_W * N_SLICES;

  typedef struct packed {
    logic gen;
    logic prop;
  } gp_t;
endpackage

// File: rtl/cla_slice.sv
module cla_slice #(
  parameter int unsigned W = cla_pkg::SLICE_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         c_in,
  output logic [W-1:0] s,
  output cla_pkg::gp_t gp
);
  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic [W-1:0] half;
  logic [W:0]   c;

  assign bit_g = x & y;
  assign bit_p = x | y;
  assign half  = x ^ y;
  assign c[0]  = c_in;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign c[i+1] = bit_g[i] | (bit_p[i] & c[i]);
      assign s[i]   = half[i] ^ c[i];
    end
  endgenerate

  always_comb begin
    logic run_p;
    gp.gen  = 1'b0;
    run_p   = 1'b1;
    for (int j = W - 1; j >= 0; j--) begin
      gp.gen = gp.gen | (run_p & bit_g[j]);
      run_p  = run_p & bit_p[j];
    end
    gp.prop = run_p;
  end
endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit #(
  parameter int unsigned N = cla_pkg::N_SLICES
) (
  input  cla_pkg::gp_t [N-1:0] gp,
  input  logic                 c0,
  output logic [N:0]           c
);
  always_comb begin
    c[0] = c0;
    for (int k = 0; k < N; k++) begin
      logic acc;
      logic term;
      acc = 1'b0;
      for (int j = 0; j <= k; j++) begin
        term = gp[j].gen;
        for (int m = j + 1; m <= k; m++) term = term & gp[m].prop;
        acc = acc | term;
      end
      term = c0;
      for (int m = 0; m <= k; m++) term = term & gp[m].prop;
      c[k+1] = acc | term;
    end
  end
endmodule

// File: rtl/cla_adder64.sv
module cla_adder64 #(
  parameter int unsigned SLICE_W  = cla_pkg::SLICE_W,
  parameter int unsigned N_SLICES = cla_pkg::N_SLICES,
  localparam int unsigned W       = SLICE_W * N_SLICES
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  output logic [W-1:0] sum,
  output logic         carry_out
);
  cla_pkg::gp_t [N_SLICES-1:0] slice_gp;
  logic [N_SLICES:0]           slice_c;

  genvar k;
  generate
    for (k = 0; k < N_SLICES; k++) begin : g_slice
      cla_slice #(.W(SLICE_W)) u_slice (
        .x    (op_a[k*SLICE_W +: SLICE_W]),
        .y    (op_b[k*SLICE_W +: SLICE_W]),
        .c_in (slice_c[k]),
        .s    (sum[k*SLICE_W +: SLICE_W]),
        .gp   (slice_gp[k])
      );
    end
  endgenerate

  cla_carry_unit #(.N(N_SLICES)) u_carry (
    .gp (slice_gp),
    .c0 (carry_in),
    .c  (slice_c)
  );

  assign carry_out = slice_c[N_SLICES];
endmodule

// File: rtl/cla_adder64_chk.sv
module cla_adder64_chk #(
  parameter int unsigned SLICE_W  = 8,
  parameter int unsigned N_SLICES = 8,
  localparam int unsigned W       = SLICE_W * N_SLICES
) (
  input logic [W-1:0]          op_a,
  input logic [W-1:0]          op_b,
  input logic                  carry_in,
  input logic [W-1:0]          sum,
  input logic                  carry_out,
  input cla_pkg::gp_t [N_SLICES-1:0] slice_gp,
  input logic [N_SLICES:0]     slice_c
);
  always_comb begin
    logic [W:0]       total;
    logic [SLICE_W:0] byte0;
    logic [SLICE_W:0] byte1;
    logic [SLICE_W:0] bytec;
    total = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};
    AST_SUM_LOW: assert (sum == total[W-1:0]);  // R1
    AST_CARRY_OUT: assert (carry_out == total[W]);  // R2
    AST_FIRST_CARRY: assert (slice_c[0] == carry_in);  // R3
    for (int k = 0; k < N_SLICES; k++) begin
      byte0 = {1'b0, op_a[k*SLICE_W +: SLICE_W]} + {1'b0, op_b[k*SLICE_W +: SLICE_W]};
      byte1 = byte0 + {{SLICE_W{1'b0}}, 1'b1};
      bytec = byte0 + {{SLICE_W{1'b0}}, slice_c[k]};
      AST_NEXT_CARRY: assert (slice_c[k+1] == bytec[SLICE_W]);  // R3
      AST_GROUP_GEN: assert (slice_gp[k].gen == byte0[SLICE_W]);  // R4
      AST_GROUP_PROP: assert ((slice_gp[k].gen | slice_gp[k].prop) == byte1[SLICE_W]);  // R4
    end
  end
endmodule

bind cla_adder64 cla_adder64_chk #(.SLICE_W(SLICE_W), .N_SLICES(N_SLICES)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .carry_in  (carry_in),
  .sum       (sum),
  .carry_out (carry_out),
  .slice_gp  (slice_gp),
  .slice_c   (slice_c)
);

// File: tb/sim_cla_adder64.sv
`timescale 1ns/1ps
module sim_cla_adder64;
  localparam int unsigned W  = 64;
  localparam int unsigned SW = 8;
  localparam int unsigned NS = 8;

  logic         clk;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic         carry_in;
  logic [W-1:0] sum;
  logic         carry_out;
  int           n_chk;
  int           n_fail;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  cla_adder64 u0 (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out)
  );

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  function automatic logic ref_carry_into(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic ci, input int k);
    logic [W:0] mask;
    logic [W:0] t;
    mask = ({{W{1'b0}}, 1'b1} << (k * SW)) - 1;
    t = (({1'b0, x} & mask) + ({1'b0, y} & mask) + {{W{1'b0}}, ci}) >> (k * SW);
    return t[0];
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic ci);
    @(posedge clk);
    op_a = x; op_b = y; carry_in = ci;
    @(negedge clk);
  endtask

  task automatic chk_full(input string req);
    logic [W:0] e;
    e = ref_add(op_a, op_b, carry_in);
    n_chk++;
    if (sum !== e[W-1:0]) begin
      n_fail++;
      $display("FAIL %s sum: actual %h expected %h", req, sum, e[W-1:0]);
    end
    n_chk++;
    if (carry_out !== e[W]) begin
      n_fail++;
      $display("FAIL %s carry_out: actual %b expected %b", req, carry_out, e[W]);
    end
  endtask

  task automatic chk_slices();
    for (int k = 0; k < NS; k++) begin
      logic [SW:0] e;
      e = {1'b0, op_a[k*SW +: SW]} + {1'b0, op_b[k*SW +: SW]}
        + {{SW{1'b0}}, ref_carry_into(op_a, op_b, carry_in, k)};
      n_chk++;
      if (sum[k*SW +: SW] !== e[SW-1:0]) begin
        n_fail++;
        $display("FAIL R3 slice %0d: actual %h expected %h", k, sum[k*SW +: SW], e[SW-1:0]);
      end
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    op_a = '0; op_b = '0; carry_in = 1'b0;
    void'($urandom(32'h5EED_0042));

    // R6: zero operands, idle state
    apply('0, '0, 1'b0);
    chk_full("R6");
    apply('0, '0, 1'b1);
    chk_full("R6");
    chk_bit("R6 bit0", sum[0], 1'b1);

    // R5: all ones with carry
    apply('1, '1, 1'b1);
    chk_full("R5");
    chk_bit("R5 carry_out", carry_out, 1'b1);

    // R7: alternating patterns, full propagate chain
    apply({32{2'b01}}, {32{2'b10}}, 1'b1);
    chk_full("R7");
    chk_bit("R7 sum zero", (sum == '0), 1'b1);
    apply({32{2'b01}}, {32{2'b10}}, 1'b0);
    chk_full("R7");
    chk_bit("R7 carry_out", carry_out, 1'b0);

    // R4: generating slice 0 forces carry into slice 1
    apply(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 1'b0);
    chk_full("R4");
    chk_bit("R4 generate", sum[8], 1'b1);
    // R4: complemented slices pass carry from slice 2 up through slice 7
    apply({{5{8'h3C}}, 8'h80, 16'h0000}, {{5{8'hC3}}, 8'h80, 16'h0000}, 1'b0);
    chk_full("R4");
    chk_bit("R4 propagate out", carry_out, 1'b1);
    chk_bit("R4 propagate sum", (sum[63:24] == '0), 1'b1);

    // R1 R2 R3: constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] x;
      logic [W-1:0] y;
      logic         ci;
      x  = {$urandom, $urandom};
      ci = 1'($urandom);
      case ($urandom % 4)
        0: y = {$urandom, $urandom};
        1: y = ~x;
        2: y = ~x ^ (64'h1 << ($urandom % 64));
        default: y = {$urandom, $urandom} & {$urandom, $urandom};
      endcase
      apply(x, y, ci);
      chk_full("R1/R2");
      if (n % 10 == 0) chk_slices();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule